// File: doc/BRIEF.md
# Triggered Signal Capture Recorder

This block is an on-chip recorder for debugging. It stores a word of up to 32 probed signals on every clock into a small capture memory. A rising edge on a start strobe arms it. It then records one word per clock until the monitored logic reports that it has gone idle. A low level on a stall input pauses the recording, so that wait states in the monitored logic do not use up the limited memory window.

A bus slave reads the results through a single select input. The select reaches a status word (sample count and a completion flag), a constant identifier, the two 32-bit words supplied from outside, and every captured word. The memory address comes from the internal sample counter while a capture runs and from the read select otherwise. The six internal control strobes (run, memory write, counter enable, status update, counter clear and address select) are brought out as ports so the surrounding logic can observe them.

Top module: `trace_recorder`

## Requirements
- R1: A rising edge of `start_i` (high now, low on the previous clock) clears the sample count and the completion flag on the next clock edge and sets `run_o`. The first word is written on the clock edge after that one, from the `probe_i` value present at that edge. A new rising edge during a capture restarts it.
- R2: While `run_o` is high, `idle_i` high ends the capture at the next clock edge. No word is written on that edge, `run_o` falls, and the completion flag is set.
- R3: At most DEPTH (32) words are stored. The count saturates at DEPTH, and further writes are blocked while `run_o` stays high until `idle_i` rises.
- R4: While `stall_n_i` is low, no word is written and the sample count holds.
- R5: The n-th word written after a start (counting from 0) lands in memory word n.
- R6: Read map of `rd_sel_i` (6 bits). Bit 5 high returns memory word `rd_sel_i[4:0]` while `run_o` is low. Bit 5 low decodes bits [1:0] as follows: 0 returns the status word, 1 returns the identifier, 2 returns `ext_a_i`, and 3 returns `ext_b_i`.
- R7: In the status word, bits [5:0] hold the number of words stored since the last start, bit 31 holds the completion flag, and all other bits are 0.
- R8: The identifier read returns the parameter ID_VALUE (default 8'h5A) in bits [7:0], with zeros above.
- R9: `cnt_clr_o` is high exactly while a start edge is present. `mem_we_o` and `cnt_en_o` are high exactly when a word is written. `addr_sel_o` is high whenever `run_o` is high. `stat_en_o` is high on a start edge, on a write and on the ending edge.
- R10: A clock edge with `rst_n` low clears `run_o`, the sample count and the completion flag, also in the middle of a capture.

Verification section for the block follows the port table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; its rising edge arms a capture |
| stall_n_i | input | 1 | Low pauses recording |
| idle_i | input | 1 | High when the monitored logic has stopped changing |
| probe_i | input | 32 | Probed signals sampled each clock |
| rd_sel_i | input | 6 | Read select |
| ext_a_i | input | 32 | External word A for read-back |
| ext_b_i | input | 32 | External word B for read-back |
| rd_data_o | output | 32 | Read data for the selected item |
| run_o | output | 1 | Capture in progress |
| mem_we_o | output | 1 | Capture memory write enable |
| cnt_en_o | output | 1 | Sample counter increment |
| stat_en_o | output | 1 | Status register update |
| cnt_clr_o | output | 1 | Sample counter clear |
| addr_sel_o | output | 1 | Memory address from counter (1) or read select (0) |

## Verification
The main capture path is driven with a mixed pattern of single and double stall cycles between runs of recording, and then ended by the idle input. Reading back the stored words shows that stalled cycles were skipped and that words landed in order. A second start without stalls runs past 32 clocks, which separates a saturating counter from one that wraps and overwrites word 0. A restart after the end shows that count and flag are cleared. A reset in the middle of a capture shows that reset takes priority over a running capture.

// File: rtl/trace_pkg.sv
// Package: shared types and field positions for the capture recorder.
// Assumes: status count field fits below STAT_DONE_BIT.
package trace_pkg;

    // Low-bit decode of the register half of the read select.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_IDENT  = 2'd1,
        SEL_EXT_A  = 2'd2,
        SEL_EXT_B  = 2'd3
    } reg_sel_e;

    // Bit of the status word that carries the completion flag.
    localparam int STAT_DONE_BIT = 31;

    // Control strobes produced by the sequencer.
    typedef struct packed {
        logic run;
        logic we;
        logic cnt_en;
        logic stat_en;
        logic cnt_clr;
        logic addr_sel;
    } ctl_t;

endpackage

// File: rtl/trace_seq.sv
// Sequencer: start-edge detect, run flag, saturating sample counter
// and status register. Assumes start_i, stall_n_i, idle_i are synchronous.
module trace_seq
    import trace_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stall_n_i,
    input  logic             idle_i,
    output ctl_t             ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] stat_cnt_o,
    output logic             stat_done_o
);

    logic             start_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stat_cnt_q;
    logic             stat_done_q;
    logic             start_edge;
    logic             full;
    logic             finish;
    logic             wr;

    // Decode the strobes of this cycle from inputs and state.
    always_comb begin
        start_edge = start_i & ~start_q;
        full       = (cnt_q == CNT_W'(DEPTH));
        finish     = run_q & idle_i & ~start_edge;
        wr         = run_q & stall_n_i & ~idle_i & ~full & ~start_edge;
    end

    // Registered copy of the start strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_i;
    end

    // Run flag: set by a start edge, cleared when the target goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (start_edge) run_q <= 1'b1;
        else if (finish)     run_q <= 1'b0;
    end

    // Sample counter: cleared on start, advanced on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start_edge) cnt_q <= '0;
        else if (wr)         cnt_q <= cnt_q + 1'b1;
    end

    // Status register: count and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_cnt_q  <= '0;
            stat_done_q <= 1'b0;
        end else if (ctl_o.stat_en) begin
            if (start_edge) begin
                stat_cnt_q  <= '0;
                stat_done_q <= 1'b0;
            end else begin
                if (wr)     stat_cnt_q  <= cnt_q + 1'b1;
                if (finish) stat_done_q <= 1'b1;
            end
        end
    end

    // Pack the control strobes for the datapath.
    always_comb begin
        ctl_o.run      = run_q;
        ctl_o.we       = wr;
        ctl_o.cnt_en   = wr;
        ctl_o.stat_en  = start_edge | wr | finish;
        ctl_o.cnt_clr  = start_edge;
        ctl_o.addr_sel = run_q;
    end

    assign cnt_o       = cnt_q;
    assign stat_cnt_o  = stat_cnt_q;
    assign stat_done_o = stat_done_q;

    assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !start_q) |=> (run_q && cnt_q == '0 && !stat_done_q));

    assert_idle_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && idle_i && !(start_i && !start_q)) |=> (!run_q && stat_done_q && $stable(cnt_q)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_n_i && !(start_i && !start_q)) |=> $stable(cnt_q));

    assert_status_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.cnt_en |=> (stat_cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/trace_mem.sv
// Capture memory: one write port; the address is chosen between the
// write counter and the read select. Contents are not reset.
module trace_mem #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              addr_sel_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     addr;

    // Address multiplexer: counter while capturing, read select otherwise.
    always_comb addr = addr_sel_i ? wr_addr_i : rd_addr_i;

    // Write one sample per enabled clock.
    always_ff @(posedge clk) begin
        if (we_i) mem[addr] <= wdata_i;
    end

    assign rdata_o = mem[addr];

    assert_write_uses_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> addr_sel_i);

endmodule

// File: rtl/trace_rdmux.sv
// Read multiplexer: memory half selected by the top select bit, register
// half decoded from the two low bits.
module trace_rdmux
    import trace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 5,
    parameter int CNT_W  = 6
) (
    input  logic [AW:0]       sel_i,
    input  logic [CNT_W-1:0]  stat_cnt_i,
    input  logic              stat_done_i,
    input  logic [7:0]        ident_i,
    input  logic [DATA_W-1:0] ext_a_i,
    input  logic [DATA_W-1:0] ext_b_i,
    input  logic [DATA_W-1:0] mem_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] status_w;
    reg_sel_e          rsel;

    // Assemble the status word.
    always_comb begin
        status_w                = '0;
        status_w[CNT_W-1:0]     = stat_cnt_i;
        status_w[STAT_DONE_BIT] = stat_done_i;
    end

    // Select the read source.
    always_comb begin
        rsel = reg_sel_e'(sel_i[1:0]);
        if (sel_i[AW]) begin
            data_o = mem_i;
        end else begin
            case (rsel)
                SEL_STATUS: data_o = status_w;
                SEL_IDENT:  data_o = DATA_W'(ident_i);
                SEL_EXT_A:  data_o = ext_a_i;
                default:    data_o = ext_b_i;
            endcase
        end
    end

endmodule

// File: rtl/trace_recorder.sv
// Top: triggered capture recorder. Ties the sequencer, capture memory and
// read multiplexer together and exposes the control strobes.
module trace_recorder
    import trace_pkg::*;
#(
    parameter int         DEPTH    = 32,
    parameter int         DATA_W   = 32,
    parameter logic [7:0] ID_VALUE = 8'h5A,
    localparam int        AW       = $clog2(DEPTH),
    localparam int        CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stall_n_i,
    input  logic              idle_i,
    input  logic [DATA_W-1:0] probe_i,
    input  logic [AW:0]       rd_sel_i,
    input  logic [DATA_W-1:0] ext_a_i,
    input  logic [DATA_W-1:0] ext_b_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              run_o,
    output logic              mem_we_o,
    output logic              cnt_en_o,
    output logic              stat_en_o,
    output logic              cnt_clr_o,
    output logic              addr_sel_o
);

    ctl_t              ctl;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  stat_cnt;
    logic              stat_done;
    logic [DATA_W-1:0] mem_rd;

    trace_seq #(.DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stall_n_i   (stall_n_i),
        .idle_i      (idle_i),
        .ctl_o       (ctl),
        .cnt_o       (cnt),
        .stat_cnt_o  (stat_cnt),
        .stat_done_o (stat_done)
    );

    trace_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ctl.we),
        .addr_sel_i (ctl.addr_sel),
        .wr_addr_i  (cnt[AW-1:0]),
        .rd_addr_i  (rd_sel_i[AW-1:0]),
        .wdata_i    (probe_i),
        .rdata_o    (mem_rd)
    );

    trace_rdmux #(.DATA_W(DATA_W), .AW(AW), .CNT_W(CNT_W)) u_rdmux (
        .sel_i       (rd_sel_i),
        .stat_cnt_i  (stat_cnt),
        .stat_done_i (stat_done),
        .ident_i     (ID_VALUE),
        .ext_a_i     (ext_a_i),
        .ext_b_i     (ext_b_i),
        .mem_i       (mem_rd),
        .data_o      (rd_data_o)
    );

    // Bring the strobes out.
    always_comb begin
        run_o      = ctl.run;
        mem_we_o   = ctl.we;
        cnt_en_o   = ctl.cnt_en;
        stat_en_o  = ctl.stat_en;
        cnt_clr_o  = ctl.cnt_clr;
        addr_sel_o = ctl.addr_sel;
    end

    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!run_o && rd_sel_i != '0 || !run_o));

    assert_run_selects_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (run_o && stall_n_i && !idle_i));

endmodule

// File: tb/trace_recorder_tb.sv
module trace_recorder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 12;
    // Row: {stall_n, idle, exp_run, exp_count[5:0]}
    localparam logic [8:0] STEPS [NSTEP] = '{
        9'b1_0_1_000001, 9'b1_0_1_000010, 9'b0_0_1_000010, 9'b0_0_1_000010,
        9'b1_0_1_000011, 9'b1_0_1_000100, 9'b0_0_1_000100, 9'b1_0_1_000101,
        9'b1_0_1_000110, 9'b1_1_0_000110, 9'b1_0_0_000110, 9'b1_0_0_000110
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, stall_n_i, idle_i;
    logic [31:0] probe_i, ext_a_i, ext_b_i, rd_data_o;
    logic [5:0]  rd_sel_i;
    logic        run_o, mem_we_o, cnt_en_o, stat_en_o, cnt_clr_o, addr_sel_o;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    trace_recorder u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stall_n_i(stall_n_i),
        .idle_i(idle_i), .probe_i(probe_i), .rd_sel_i(rd_sel_i),
        .ext_a_i(ext_a_i), .ext_b_i(ext_b_i), .rd_data_o(rd_data_o),
        .run_o(run_o), .mem_we_o(mem_we_o), .cnt_en_o(cnt_en_o),
        .stat_en_o(stat_en_o), .cnt_clr_o(cnt_clr_o), .addr_sel_o(addr_sel_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] pv(int i);
        return 32'hA500_0000 | (i * 32'h0001_0203);
    endfunction

    function automatic logic [31:0] pw(int i);
        return 32'h3C00_0000 ^ (i * 32'h0102_0408);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read(logic [5:0] sel, string req, logic [31:0] exp);
        rd_sel_i = sel;
        #1;
        check(req, rd_data_o, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; stall_n_i = 1'b1; idle_i = 1'b0;
        probe_i = '0; rd_sel_i = '0;
        ext_a_i = 32'hDEAD_0001; ext_b_i = 32'hBEEF_0002;
        repeat (3) tick();
        check("R10 run after reset", 32'(run_o), 32'd0);
        read(6'd0, "R10 status after reset", 32'h0);
        rst_n = 1'b1;
        tick();
        read(6'd1, "R8 identifier", 32'h0000_005A);
        read(6'd2, "R6 ext A", 32'hDEAD_0001);
        read(6'd3, "R6 ext B", 32'hBEEF_0002);
        rd_sel_i = 6'd0;

        // First capture: start edge, then the stimulus table.
        start_i = 1'b1;
        #1;
        check("R9 clear strobe on start edge", 32'(cnt_clr_o), 32'd1);
        tick();
        check("R1 run after start", 32'(run_o), 32'd1);
        check("R9 clear strobe gone", 32'(cnt_clr_o), 32'd0);
        check("R9 address from counter", 32'(addr_sel_o), 32'd1);
        check("R9 write strobe", 32'(mem_we_o), 32'd1);
        check("R9 counter strobe", 32'(cnt_en_o), 32'd1);
        check("R9 status strobe", 32'(stat_en_o), 32'd1);
        check("R1 no word before first sample edge", rd_data_o, 32'h0);
        for (int i = 0; i < NSTEP; i++) begin
            stall_n_i = STEPS[i][8];
            idle_i    = STEPS[i][7];
            probe_i   = pv(i);
            if (i == 2) begin
                #1;
                check("R4 no write while stalled", 32'(mem_we_o), 32'd0);
            end
            tick();
            check("R4 run flag", 32'(run_o), 32'(STEPS[i][6]));
            check("R4 sample count", rd_data_o & 32'h3F, 32'(STEPS[i][5:0]));
        end
        idle_i = 1'b0;
        read(6'd0, "R2 R7 status word at end", 32'h8000_0006);
        read(6'h20, "R5 word 0", pv(0));
        read(6'h21, "R5 word 1", pv(1));
        read(6'h22, "R4 word 2 skips stall", pv(4));
        read(6'h23, "R5 word 3", pv(5));
        read(6'h24, "R4 word 4 skips stall", pv(7));
        read(6'h25, "R2 word 5 last before idle", pv(8));

        // Second capture: run past the memory size.
        start_i = 1'b0;
        rd_sel_i = 6'd0;
        tick();
        start_i = 1'b1;
        tick();
        read(6'd0, "R1 restart clears count and flag", 32'h0);
        for (int k = 0; k < 40; k++) begin
            probe_i = pw(k);
            tick();
        end
        read(6'd0, "R3 count saturates", 32'd32);
        check("R3 still running when full", 32'(run_o), 32'd1);
        check("R3 write blocked when full", 32'(mem_we_o), 32'd0);
        idle_i = 1'b1;
        tick();
        idle_i = 1'b0;
        check("R2 run ends on idle", 32'(run_o), 32'd0);
        read(6'd0, "R2 R7 full status", 32'h8000_0020);
        read(6'h20, "R3 word 0 not overwritten", pw(0));
        read(6'h31, "R5 word 17", pw(17));
        read(6'h3F, "R5 word 31", pw(31));

        // Reset in the middle of a capture.
        start_i = 1'b0;
        rd_sel_i = 6'd0;
        tick();
        start_i = 1'b1;
        repeat (3) tick();
        rst_n = 1'b0;
        tick();
        check("R10 run cleared mid capture", 32'(run_o), 32'd0);
        read(6'd0, "R10 status cleared mid capture", 32'h0);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule